// File: doc/BRIEF.md
# NAND Card Bus Access Port

This block sits between a simple host register interface and an 8-bit NAND card bus. The host reaches three registers. The data register turns each host access into cycles on the card bus. A byte access makes one bus cycle. A 32-bit access makes four back-to-back byte cycles, least-significant byte first. The host request is held, and the acknowledge withheld, until the last of those cycles has finished. The control register drives the card lines directly: command latch, address latch, chip enable and write-protect release. It also carries an enable for the external ECC engine and a readback mode bit. The status register shows the card ready/busy line.

When the readback mode bit is set, a 32-bit read of the data register makes no bus cycle. It returns an ECC word from the external engine instead. Which word comes back depends on the direction of the most recent bus transfer. After a read transfer it is the correction result. After a write transfer it is the pair of generated checksums, served on alternate reads. Byte accesses are unaffected by the mode bit.

Each bus cycle holds its write or read strobe low for `STROBE_CLKS` clocks, then high for at least `GAP_CLKS` clocks. Read data is captured on the clock edge at which the read strobe rises.

Sequencer states: `SQ_IDLE` goes to `SQ_STROBE` on a start. `SQ_STROBE` goes to `SQ_GAP` after `STROBE_CLKS` clocks. `SQ_GAP` goes back to `SQ_STROBE` if bytes remain, or to `SQ_DONE` after `GAP_CLKS` clocks. `SQ_DONE` goes to `SQ_IDLE`.

Host states: `HS_IDLE` goes to `HS_BUS` for a data access that needs bus cycles. For every other access it goes directly to `HS_RESP`. `HS_BUS` goes to `HS_RESP` when the sequencer finishes. `HS_RESP` goes to `HS_IDLE`.

Top module: `nand_card_port`

## Requirements
- R1: After reset, host_ack is 0, both strobes are high, the command and address latch lines are 0, card_ce_n is 1, card_wp_n is 0 and ecc_engine_en is 0.
- R2: A byte access to the data register (offset 0, host_word=0) makes exactly one bus cycle. A write drives host_wdata[7:0] with card_dout_en high. A read returns the bus byte in host_rdata[7:0], with bits 31:8 zero.
- R3: A 32-bit access to the data register (host_word=1) makes four bus cycles. Byte k uses bits 8k+7:8k, from k=0 to k=3. host_ack comes only after the fourth cycle.
- R4: A write to the control register (offset 1) takes bits 7:0. Bit 0 drives card_cle, bit 1 drives card_ale, bit 4 set drives card_ce_n low, bit 5 drives ecc_engine_en, and bit 7 set drives card_wp_n high. A read of offset 1 returns the stored byte. The register does not change while bus cycles run.
- R5: With control bit 6 set, a 32-bit read of the data register makes no bus cycle. If the last bus transfer was a read, or if there has been no transfer since reset, it returns ecc_fix_word unchanged. Layout of that word: bits 7:0 and 23:16 are the error byte location of page halves 0 and 1. Bits 15:8 and 31:24 are their flags: bits 2:0 give the bit location, 0x10 means no error, 0x20 correctable, 0x40 uncorrectable.
- R6: With control bit 6 set, and the last bus transfer a write, successive 32-bit data reads return ecc_gen_lo, then ecc_gen_hi, and keep alternating. Any bus cycle restarts the order at ecc_gen_lo.
- R7: With control bit 6 set, a byte read of the data register still makes one bus cycle and returns card data.
- R8: Status register (offset 2): bit 7 reads 1 while card_rb_n is low, two clocks after the line changes. All other bits read 0. Writes to offsets 2 and 3 change no register.
- R9: Only one strobe is low at a time. Each strobe low lasts exactly STROBE_CLKS clocks. Between strobes there are at least GAP_CLKS high clocks.
- R10: host_ack is a single-clock pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Request, held until host_ack |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Register offset: 0 data, 1 control, 2 status |
| host_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with host_ack |
| host_ack | output | 1 | Access complete |
| card_din | input | 8 | Data from the card bus |
| card_dout | output | 8 | Data to the card bus |
| card_dout_en | output | 1 | Drive enable for card_dout |
| card_we_n | output | 1 | Write strobe, active low |
| card_re_n | output | 1 | Read strobe, active low |
| card_cle | output | 1 | Command latch enable |
| card_ale | output | 1 | Address latch enable |
| card_ce_n | output | 1 | Card enable, active low |
| card_wp_n | output | 1 | Write protect, low = protected |
| card_rb_n | input | 1 | Ready/busy from the card, low = busy |
| ecc_engine_en | output | 1 | Enable for the external ECC engine |
| ecc_fix_word | input | 32 | Correction result from the ECC engine |
| ecc_gen_lo | input | 32 | First generated checksum word |
| ecc_gen_hi | input | 32 | Second generated checksum word |

## Verification
The data register is exercised with a seeded random mix of byte and 32-bit reads and writes, interleaved with control writes and status reads. This separates the one-cycle path from the four-cycle path. Byte lane order is checked against a logged card bus. Directed sequences toggle the readback mode bit after write and after read transfers. They show whether the ECC source follows the last transfer direction and whether the checksum order restarts after bus activity. They also show that byte reads still reach the card in that mode. Strobe width and gap are measured on every cycle, and the ready/busy status is checked in both line states.

// File: rtl/nand_port_pkg.sv
package nand_port_pkg;
    localparam logic [1:0] REG_DATA = 2'd0;
    localparam logic [1:0] REG_CTRL = 2'd1;
    localparam logic [1:0] REG_STAT = 2'd2;

    localparam int CTL_CMD   = 0;
    localparam int CTL_ADR   = 1;
    localparam int CTL_CE    = 4;
    localparam int CTL_ECCEN = 5;
    localparam int CTL_ECCRD = 6;
    localparam int CTL_WREN  = 7;

    typedef enum logic [1:0] {SQ_IDLE, SQ_STROBE, SQ_GAP, SQ_DONE} seq_state_t;
    typedef enum logic [1:0] {HS_IDLE, HS_BUS, HS_RESP} host_state_t;
endpackage

// File: rtl/nand_ctl_regs.sv
module nand_ctl_regs
    import nand_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_we,
    input  logic [7:0] ctl_wdata,
    input  logic       rb_n,
    output logic [7:0] ctl_q,
    output logic [7:0] stat_q,
    output logic       cle,
    output logic       ale,
    output logic       ce_n,
    output logic       wp_n,
    output logic       ecc_en,
    output logic       ecc_rd_mode
);
    logic [1:0] rb_sync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q   <= 8'h00;
            rb_sync <= 2'b11;
        end else begin
            if (ctl_we) ctl_q <= ctl_wdata;
            rb_sync <= {rb_sync[0], rb_n};
        end
    end

    always_comb begin
        cle         = ctl_q[CTL_CMD];
        ale         = ctl_q[CTL_ADR];
        ce_n        = !ctl_q[CTL_CE];
        wp_n        = ctl_q[CTL_WREN];
        ecc_en      = ctl_q[CTL_ECCEN];
        ecc_rd_mode = ctl_q[CTL_ECCRD];
        stat_q      = {!rb_sync[1], 7'b0};
    end
endmodule

// File: rtl/nand_byte_seq.sv
module nand_byte_seq
    import nand_port_pkg::*;
#(
    parameter int STROBE_CLKS = 2,
    parameter int GAP_CLKS    = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        dir_wr,
    input  logic        four,
    input  logic [31:0] wdata,
    input  logic [7:0]  nd_din,
    output logic        busy,
    output logic        done,
    output logic [31:0] rdata,
    output logic [7:0]  nd_dout,
    output logic        nd_dout_en,
    output logic        nd_we_n,
    output logic        nd_re_n
);
    localparam int CNT_MAX = (STROBE_CLKS > GAP_CLKS) ? STROBE_CLKS : GAP_CLKS;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] STB_LAST = CW'(STROBE_CLKS - 1);
    localparam logic [CW-1:0] GAP_LAST = CW'(GAP_CLKS - 1);
    localparam logic [CW:0]   STB_RUN  = (CW+1)'(STROBE_CLKS);

    seq_state_t     state;
    logic [CW-1:0]  cnt;
    logic [1:0]     idx;
    logic [1:0]     last_idx;
    logic           wr_q;
    logic [31:0]    wbuf;
    logic [31:0]    rbuf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            cnt      <= '0;
            idx      <= 2'd0;
            last_idx <= 2'd0;
            wr_q     <= 1'b0;
            wbuf     <= '0;
            rbuf     <= '0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (start) begin
                        wr_q     <= dir_wr;
                        wbuf     <= wdata;
                        last_idx <= four ? 2'd3 : 2'd0;
                        idx      <= 2'd0;
                        cnt      <= '0;
                        rbuf     <= '0;
                        state    <= SQ_STROBE;
                    end
                end
                SQ_STROBE: begin
                    if (cnt == STB_LAST) begin
                        cnt <= '0;
                        if (!wr_q) rbuf[{idx, 3'b000} +: 8] <= nd_din;
                        state <= SQ_GAP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_GAP: begin
                    if (cnt == GAP_LAST) begin
                        cnt <= '0;
                        if (idx == last_idx) begin
                            state <= SQ_DONE;
                        end else begin
                            idx   <= idx + 2'd1;
                            state <= SQ_STROBE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_DONE: state <= SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        nd_we_n    = 1'b1;
        nd_re_n    = 1'b1;
        nd_dout_en = 1'b0;
        busy       = 1'b1;
        done       = 1'b0;
        nd_dout    = wbuf[{idx, 3'b000} +: 8];
        rdata      = rbuf;
        unique case (state)
            SQ_IDLE:   busy = 1'b0;
            SQ_STROBE: begin
                nd_we_n    = !wr_q;
                nd_re_n    = wr_q;
                nd_dout_en = wr_q;
            end
            SQ_GAP:    nd_dout_en = wr_q;
            SQ_DONE:   done = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    // strobe-low run length, used only by the width check
    logic [CW:0] low_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    low_run <= '0;
        else if (!nd_we_n || !nd_re_n) low_run <= low_run + 1'b1;
        else                           low_run <= '0;
    end

    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nd_we_n && !nd_re_n));
    assert_strobe_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (nd_we_n && nd_re_n && low_run != '0) |-> (low_run == STB_RUN));
    assert_no_drive_on_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !nd_re_n |-> !nd_dout_en);
endmodule

// File: rtl/nand_ecc_sel.sv
module nand_ecc_sel (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_start,
    input  logic        bus_dir_wr,
    input  logic        ecc_rd,
    input  logic [31:0] fix_word,
    input  logic [31:0] gen_lo,
    input  logic [31:0] gen_hi,
    output logic [31:0] ecc_word
);
    logic last_wr;
    logic gen_ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_wr <= 1'b0;
            gen_ptr <= 1'b0;
        end else if (bus_start) begin
            last_wr <= bus_dir_wr;
            gen_ptr <= 1'b0;
        end else if (ecc_rd && last_wr) begin
            gen_ptr <= !gen_ptr;
        end
    end

    always_comb begin
        if (!last_wr)     ecc_word = fix_word;
        else if (gen_ptr) ecc_word = gen_hi;
        else              ecc_word = gen_lo;
    end

    assert_ecc_no_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_start && ecc_rd));
    assert_ptr_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> !gen_ptr);
endmodule

// File: rtl/nand_card_port.sv
module nand_card_port
    import nand_port_pkg::*;
#(
    parameter int STROBE_CLKS = 2,
    parameter int GAP_CLKS    = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_req,
    input  logic        host_wr,
    input  logic [1:0]  host_addr,
    input  logic        host_word,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        host_ack,
    input  logic [7:0]  card_din,
    output logic [7:0]  card_dout,
    output logic        card_dout_en,
    output logic        card_we_n,
    output logic        card_re_n,
    output logic        card_cle,
    output logic        card_ale,
    output logic        card_ce_n,
    output logic        card_wp_n,
    input  logic        card_rb_n,
    output logic        ecc_engine_en,
    input  logic [31:0] ecc_fix_word,
    input  logic [31:0] ecc_gen_lo,
    input  logic [31:0] ecc_gen_hi
);
    host_state_t hstate;
    logic [31:0] rdata_q;
    logic        word_q;
    logic        wr_q;

    logic [7:0]  ctl_q;
    logic [7:0]  stat_q;
    logic        ecc_rd_mode;
    logic        seq_busy;
    logic        seq_done;
    logic [31:0] seq_rdata;
    logic [31:0] ecc_word;

    logic accept, is_data, ecc_hit, bus_start, ecc_rd, ctl_we;

    always_comb begin
        accept    = (hstate == HS_IDLE) && host_req;
        is_data   = (host_addr == REG_DATA);
        ecc_hit   = host_word && !host_wr && ecc_rd_mode;
        bus_start = accept && is_data && !ecc_hit;
        ecc_rd    = accept && is_data && ecc_hit;
        ctl_we    = accept && host_wr && (host_addr == REG_CTRL);
    end

    nand_ctl_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_we     (ctl_we),
        .ctl_wdata  (host_wdata[7:0]),
        .rb_n       (card_rb_n),
        .ctl_q      (ctl_q),
        .stat_q     (stat_q),
        .cle        (card_cle),
        .ale        (card_ale),
        .ce_n       (card_ce_n),
        .wp_n       (card_wp_n),
        .ecc_en     (ecc_engine_en),
        .ecc_rd_mode(ecc_rd_mode)
    );

    nand_byte_seq #(.STROBE_CLKS(STROBE_CLKS), .GAP_CLKS(GAP_CLKS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (bus_start),
        .dir_wr    (host_wr),
        .four      (host_word),
        .wdata     (host_wdata),
        .nd_din    (card_din),
        .busy      (seq_busy),
        .done      (seq_done),
        .rdata     (seq_rdata),
        .nd_dout   (card_dout),
        .nd_dout_en(card_dout_en),
        .nd_we_n   (card_we_n),
        .nd_re_n   (card_re_n)
    );

    nand_ecc_sel u_ecc (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_start (bus_start),
        .bus_dir_wr(host_wr),
        .ecc_rd    (ecc_rd),
        .fix_word  (ecc_fix_word),
        .gen_lo    (ecc_gen_lo),
        .gen_hi    (ecc_gen_hi),
        .ecc_word  (ecc_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hstate  <= HS_IDLE;
            rdata_q <= '0;
            word_q  <= 1'b0;
            wr_q    <= 1'b0;
        end else begin
            unique case (hstate)
                HS_IDLE: begin
                    if (host_req) begin
                        word_q <= host_word;
                        wr_q   <= host_wr;
                        if (bus_start) begin
                            hstate <= HS_BUS;
                        end else begin
                            if (host_wr)                     rdata_q <= '0;
                            else if (is_data)                rdata_q <= ecc_word;
                            else if (host_addr == REG_CTRL)  rdata_q <= {24'b0, ctl_q};
                            else if (host_addr == REG_STAT)  rdata_q <= {24'b0, stat_q};
                            else                             rdata_q <= '0;
                            hstate <= HS_RESP;
                        end
                    end
                end
                HS_BUS: begin
                    if (seq_done) begin
                        if (wr_q)        rdata_q <= '0;
                        else if (word_q) rdata_q <= seq_rdata;
                        else             rdata_q <= {24'b0, seq_rdata[7:0]};
                        hstate <= HS_RESP;
                    end
                end
                HS_RESP: hstate <= HS_IDLE;
                default: hstate <= HS_IDLE;
            endcase
        end
    end

    always_comb begin
        host_ack   = (hstate == HS_RESP);
        host_rdata = rdata_q;
    end

    assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);
    assert_ctl_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hstate == HS_BUS) |=> $stable(ctl_q));
    assert_ack_after_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hstate == HS_BUS && !seq_done) |=> !host_ack);
    assert_seq_idle_outside_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hstate == HS_IDLE) |-> !seq_busy);
endmodule

// File: tb/nand_card_port_tb.sv
module nand_card_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int STB = 3;
    localparam int GAP = 2;
    localparam logic [31:0] FIX = 32'h1000_252A;
    localparam logic [31:0] GLO = 32'hC3A5_5A3C;
    localparam logic [31:0] GHI = 32'h0F1E_2D4B;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_req = 1'b0, host_wr = 1'b0, host_word = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic host_ack;
    logic [7:0] card_din = 8'h00;
    logic [7:0] card_dout;
    logic card_dout_en, card_we_n, card_re_n, card_cle, card_ale, card_ce_n, card_wp_n;
    logic card_rb_n = 1'b1;
    logic ecc_engine_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_card_port #(.STROBE_CLKS(STB), .GAP_CLKS(GAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_word(host_word), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_ack(host_ack), .card_din(card_din),
        .card_dout(card_dout), .card_dout_en(card_dout_en), .card_we_n(card_we_n),
        .card_re_n(card_re_n), .card_cle(card_cle), .card_ale(card_ale),
        .card_ce_n(card_ce_n), .card_wp_n(card_wp_n), .card_rb_n(card_rb_n),
        .ecc_engine_en(ecc_engine_en), .ecc_fix_word(FIX), .ecc_gen_lo(GLO),
        .ecc_gen_hi(GHI)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] src(input int i);
        return 8'((i * 29 + 92) & 255);
    endfunction

    // card bus model: write log and read responder
    logic [7:0] wlog [0:1023];
    logic       wen_log [0:1023];
    int wcnt = 0;
    int rcnt = 0;
    always @(posedge card_we_n) if (rst_n) begin
        if (wcnt < 1024) begin
            wlog[wcnt]    = card_dout;
            wen_log[wcnt] = card_dout_en;
        end
        wcnt++;
    end
    always @(negedge card_re_n) if (rst_n) begin
        card_din = src(rcnt);
        rcnt++;
    end

    // strobe width and gap monitor (R9)
    int lowc = 0;
    int hic = 100;
    always @(negedge clk) if (rst_n) begin
        if (!card_we_n && !card_re_n) chk("R9 both strobes low", 1, 0);
        if (!card_we_n || !card_re_n) begin
            if (lowc == 0 && hic < GAP) chk("R9 gap", hic, GAP);
            lowc++;
            hic = 0;
        end else begin
            if (lowc != 0) chk("R9 strobe width", lowc, STB);
            lowc = 0;
            hic++;
        end
    end

    // reference model state
    logic [7:0] ctl_m = 8'h00;
    bit last_wr_m = 0;
    bit ptr_m = 0;

    function automatic logic [31:0] ecc_exp();
        if (!last_wr_m) return FIX;
        return ptr_m ? GHI : GLO;
    endfunction

    task automatic acc(input bit wr, input logic [1:0] a, input bit w,
                       input logic [31:0] d, output logic [31:0] r);
        int n;
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_addr = a; host_word = w; host_wdata = d;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!host_ack && n < 2000);
        if (!host_ack) chk("R10 ack timeout", 0, 1);
        r = host_rdata;
        host_req = 1'b0;
        @(negedge clk);
        chk("R10 ack single pulse", host_ack, 0);
    endtask

    task automatic data_op(input bit wr, input bit w, input logic [31:0] d);
        logic [31:0] r, exp;
        int w0, r0;
        bit ecc;
        w0 = wcnt; r0 = rcnt;
        ecc = w && !wr && ctl_m[6];
        acc(wr, 2'd0, w, d, r);
        if (ecc) begin
            chk(last_wr_m ? "R6 checksum word" : "R5 correction word", r, ecc_exp());
            chk("R5 no bus cycle on ecc read", wcnt + rcnt, w0 + r0);
            if (last_wr_m) ptr_m = !ptr_m;
        end else if (wr) begin
            chk(w ? "R3 write cycle count" : "R2 write cycle count", wcnt, w0 + (w ? 4 : 1));
            for (int k = 0; k < (w ? 4 : 1); k++) begin
                chk(w ? "R3 write byte lane" : "R2 write byte", {24'b0, wlog[(w0+k)%1024]}, {24'b0, d[8*k +: 8]});
                chk("R2 drive enable", {31'b0, wen_log[(w0+k)%1024]}, 1);
            end
            last_wr_m = 1; ptr_m = 0;
        end else begin
            chk(w ? "R3 read cycle count" : (ctl_m[6] ? "R7 byte read cycle" : "R2 read cycle count"),
                rcnt, r0 + (w ? 4 : 1));
            exp = '0;
            for (int k = 0; k < (w ? 4 : 1); k++) exp[8*k +: 8] = src(r0 + k);
            chk(w ? "R3 read assembly" : "R2 byte read data", r, exp);
            last_wr_m = 0; ptr_m = 0;
        end
    endtask

    task automatic ctl_write(input logic [7:0] v);
        logic [31:0] r;
        acc(1'b1, 2'd1, 1'b0, {24'hABCDEF, v}, r);
        ctl_m = v;
        chk("R4 cle", card_cle, v[0]);
        chk("R4 ale", card_ale, v[1]);
        chk("R4 ce_n", card_ce_n, !v[4]);
        chk("R4 ecc enable", ecc_engine_en, v[5]);
        chk("R4 wp_n", card_wp_n, v[7]);
        acc(1'b0, 2'd1, 1'b0, 32'h0, r);
        chk("R4 readback", r, {24'b0, v});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk("watchdog", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 ack", host_ack, 0);
        chk("R1 we_n", card_we_n, 1);
        chk("R1 re_n", card_re_n, 1);
        chk("R1 cle", card_cle, 0);
        chk("R1 ale", card_ale, 0);
        chk("R1 ce_n", card_ce_n, 1);
        chk("R1 wp_n", card_wp_n, 0);
        chk("R1 ecc_en", ecc_engine_en, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R5: no transfer since reset selects correction result
        ctl_write(8'h50);
        data_op(1'b0, 1'b1, 32'h0);
        ctl_write(8'h90);
        data_op(1'b1, 1'b0, 32'h0000_00A7);
        data_op(1'b1, 1'b1, 32'h1234_5678);
        data_op(1'b0, 1'b0, 32'h0);
        data_op(1'b0, 1'b1, 32'h0);

        // R6: checksum alternation after write, then restart
        ctl_write(8'hF3);
        data_op(1'b1, 1'b1, 32'hDEAD_BEEF);
        data_op(1'b0, 1'b1, 32'h0);
        data_op(1'b0, 1'b1, 32'h0);
        data_op(1'b0, 1'b1, 32'h0);
        data_op(1'b1, 1'b0, 32'h0000_0011);
        data_op(1'b0, 1'b1, 32'h0);
        // R7: byte read still reaches the card, then correction result
        data_op(1'b0, 1'b0, 32'h0);
        data_op(1'b0, 1'b1, 32'h0);

        // R8: status busy and write ignore
        card_rb_n = 1'b0;
        repeat (4) @(negedge clk);
        acc(1'b0, 2'd2, 1'b0, 32'h0, r);
        chk("R8 status busy", r, 32'h80);
        card_rb_n = 1'b1;
        repeat (4) @(negedge clk);
        acc(1'b0, 2'd2, 1'b0, 32'h0, r);
        chk("R8 status ready", r, 32'h00);
        acc(1'b1, 2'd2, 1'b0, 32'hFFFF_FFFF, r);
        acc(1'b1, 2'd3, 1'b0, 32'hFFFF_FFFF, r);
        acc(1'b0, 2'd1, 1'b0, 32'h0, r);
        chk("R8 status write ignored (ctl)", r, {24'b0, ctl_m});
        acc(1'b0, 2'd2, 1'b0, 32'h0, r);
        chk("R8 status write ignored (stat)", r, 32'h00);

        // constrained random mix
        for (int i = 0; i < 80; i++) begin
            int op;
            logic [31:0] d;
            op = int'($urandom % 6);
            d = $urandom;
            case (op)
                0: data_op(1'b1, 1'b0, d);
                1: data_op(1'b1, 1'b1, d);
                2: data_op(1'b0, 1'b0, d);
                3: data_op(1'b0, 1'b1, d);
                4: ctl_write(d[7:0] | 8'h10);
                default: begin
                    acc(1'b0, 2'd2, 1'b0, 32'h0, r);
                    chk("R8 status random", r, 32'h00);
                end
            endcase
        end

        repeat (5) @(negedge clk);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule